// File: doc/BRIEF.md
# Key-Protected Power Mode Controller

This block holds the low-power mode that software has chosen and applies it to the clock tree when the processor goes to sleep. The mode register is guarded: it only takes a write after software has put a fixed pair of 16-bit key words into a key register, in order. Any other register write in the meantime drops the guard back to locked. A wrong key value does the same, and so does a single accepted mode write. The key register reads back how far the unlock has got, so software can see it.

When the processor's sleep indication rises and the stored mode is not active, the block applies that mode. It does this by clearing gate enables for the core clock, the bus clock, the interrupt-controller clock and a set of peripheral clocks. A qualifying wake input brings the applied mode back to active on the next edge. Per-peripheral clock-off bits set by software act only while the applied mode is active or core sleep. Both deeper modes force every peripheral clock off.

The register port is a plain single-cycle write strobe with combinational read data. The sleep indication, the wake inputs and the gate enables are level signals. None of them carries a handshake, so there is no back-pressure anywhere in the block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the stored mode reads 00 and the applied mode reads 00 (active). The lock stage reads 0, the clock-off bits read 0, and every gate enable is 1.
- R2: The lock stage is read at address 0 (0 locked, 1 first key seen, 2 unlocked). Writing 0x4859 to address 0 while locked moves it to 1. Writing 0xF27B to address 0 at stage 1 moves it to 2.
- R3: A write to the mode register (address 1, bits [1:0]) at stage 0 or 1 leaves the stored mode unchanged.
- R4: A mode write at stage 2 stores bits [1:0] (00 active, 01 core sleep, 10 system sleep, 11 hibernate). Address 1 reads the stored value back, and the lock stage returns to 0 at once.
- R5: At stage 0, a key write of any value other than 0x4859 leaves the stage at 0. At stage 1, any value other than 0xF27B returns it to 0. Any key write at stage 2 returns it to 0.
- R6: A write to any address other than 0 returns the lock stage to 0. Reads never change it.
- R7: On the edge where the sleep input is 1 and was 0 on the previous edge, while the applied mode is active, the applied mode (read at address 3) becomes the stored mode. A stored mode of 00 changes nothing.
- R8: The core clock enable is 0 in every mode except active. The bus clock enable is 0 only in system sleep and hibernate. The interrupt-controller clock enable is 0 only in hibernate.
- R9: Address 2 holds one clock-off bit per peripheral and needs no key. In active and core sleep, each peripheral enable is the inverse of its bit. In system sleep and hibernate, every peripheral enable is 0.
- R10: In core sleep or system sleep, any set wake bit returns the applied mode to active on the next edge. In hibernate, only wake bits that are also set in the hibernate wake mask (default bits 3..0) do this. Waking leaves the stored mode unchanged.
- R11: After a wake, sleep is entered again only on a new 0-to-1 transition of the sleep input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| cpu_sleep | input | 1 | Processor is in sleep |
| wake_src | input | NWAKE | Wake event inputs |
| core_clk_en | output | 1 | Core clock gate enable |
| bus_clk_en | output | 1 | Bus clock gate enable |
| irq_clk_en | output | 1 | Interrupt-controller clock gate enable |
| periph_clk_en | output | NPERIPH | Peripheral clock gate enables |

## Verification
The assertions assume that the processor holds its sleep indication high for as long as a low-power mode is applied. In other words, the core clock is never gated while the processor believes it is running. The random stimulus follows this rule: the bench keeps the sleep input at 1 whenever its model shows a non-active applied mode, and it changes that input freely only while the model is active. Key writes are weighted toward the two valid words, so that every unlock stage and every relock path is reached often.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_CORE   = 2'b01,
    PM_SYS    = 2'b10,
    PM_HIB    = 2'b11
  } pm_mode_e;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_FIRST = 2'd1,
    LK_OPEN  = 2'd2
  } lock_e;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 16'h4859;
  localparam logic [DATA_W-1:0] KEY_SECOND = 16'hF27B;

  localparam logic [ADDR_W-1:0] A_KEY   = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CGOFF = 2'd2;
  localparam logic [ADDR_W-1:0] A_STATE = 2'd3;
endpackage

// File: rtl/pmc_key_guard.sv
module pmc_key_guard
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output lock_e             stage,
  output logic              open_now
);
  lock_e stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    if (wr) begin
      if (addr == A_KEY) begin
        unique case (stage_q)
          LK_IDLE:  stage_d = (wdata == KEY_FIRST)  ? LK_FIRST : LK_IDLE;
          LK_FIRST: stage_d = (wdata == KEY_SECOND) ? LK_OPEN  : LK_IDLE;
          default:  stage_d = LK_IDLE;
        endcase
      end else begin
        stage_d = LK_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= LK_IDLE;
    else        stage_q <= stage_d;
  end

  assign stage    = stage_q;
  assign open_now = (stage_q == LK_OPEN);

  // R2: the open stage can only follow the first-key stage
  a_r2_open_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == LK_IDLE) |=> (stage_q != LK_OPEN));

  // R4: any write while open closes the guard
  a_r4_relock_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == LK_OPEN && wr) |=> (stage_q == LK_IDLE));

  // R6: without a write the stage holds
  a_r6_stage_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(stage_q));
endmodule

// File: rtl/pmc_mode_seq.sv
module pmc_mode_seq
  import pmc_pkg::*;
#(
  parameter int                 NWAKE         = 8,
  parameter logic [NWAKE-1:0]   HIB_WAKE_MASK = 8'h0F
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_sleep,
  input  logic [NWAKE-1:0] wake_src,
  input  pm_mode_e         mode_req,
  output pm_mode_e         applied
);
  pm_mode_e app_q, app_d;
  logic     sleep_q;
  logic     sleep_rise;
  logic     wake_ok;

  assign sleep_rise = cpu_sleep && !sleep_q;
  assign wake_ok    = (app_q == PM_HIB) ? |(wake_src & HIB_WAKE_MASK) : |wake_src;

  always_comb begin
    app_d = app_q;
    if (app_q == PM_ACTIVE) begin
      if (sleep_rise) app_d = mode_req;
    end else if (wake_ok) begin
      app_d = PM_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_q   <= PM_ACTIVE;
      sleep_q <= 1'b0;
    end else begin
      app_q   <= app_d;
      sleep_q <= cpu_sleep;
    end
  end

  assign applied = app_q;

  // R10: a qualifying wake always lands in active
  a_r10_wake_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (app_q != PM_ACTIVE && |(wake_src & HIB_WAKE_MASK)) |=> (app_q == PM_ACTIVE));

  // R11: leaving active needs a sleep edge
  a_r11_entry_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (app_q == PM_ACTIVE && !(cpu_sleep && !sleep_q)) |=> (app_q == PM_ACTIVE));
endmodule

// File: rtl/pmc_gate_map.sv
module pmc_gate_map
  import pmc_pkg::*;
#(
  parameter int NPERIPH = 8
)(
  input  pm_mode_e           applied,
  input  logic [NPERIPH-1:0] cg_off,
  output logic               core_en,
  output logic               bus_en,
  output logic               irq_en,
  output logic [NPERIPH-1:0] periph_en
);
  logic periph_live;

  always_comb begin
    core_en     = 1'b1;
    bus_en      = 1'b1;
    irq_en      = 1'b1;
    periph_live = 1'b1;
    unique case (applied)
      PM_ACTIVE: ;
      PM_CORE:   core_en = 1'b0;
      PM_SYS: begin
        core_en     = 1'b0;
        bus_en      = 1'b0;
        periph_live = 1'b0;
      end
      default: begin
        core_en     = 1'b0;
        bus_en      = 1'b0;
        irq_en      = 1'b0;
        periph_live = 1'b0;
      end
    endcase
  end

  for (genvar i = 0; i < NPERIPH; i++) begin : g_periph
    assign periph_en[i] = periph_live & ~cg_off[i];
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int               NPERIPH       = 8,
  parameter int               NWAKE         = 8,
  parameter logic [NWAKE-1:0] HIB_WAKE_MASK = 8'h0F
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  input  logic               cpu_sleep,
  input  logic [NWAKE-1:0]   wake_src,
  output logic               core_clk_en,
  output logic               bus_clk_en,
  output logic               irq_clk_en,
  output logic [NPERIPH-1:0] periph_clk_en
);
  localparam int CG_PAD = DATA_W - NPERIPH;

  lock_e              stage;
  logic               unlocked;
  pm_mode_e           mode_q;
  pm_mode_e           applied;
  logic [NPERIPH-1:0] cg_off_q;

  pmc_key_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .stage    (stage),
    .open_now (unlocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PM_ACTIVE;
      cg_off_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MODE && unlocked) mode_q <= pm_mode_e'(bus_wdata[1:0]);
      if (bus_addr == A_CGOFF)            cg_off_q <= bus_wdata[NPERIPH-1:0];
    end
  end

  pmc_mode_seq #(
    .NWAKE         (NWAKE),
    .HIB_WAKE_MASK (HIB_WAKE_MASK)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_sleep (cpu_sleep),
    .wake_src  (wake_src),
    .mode_req  (mode_q),
    .applied   (applied)
  );

  pmc_gate_map #(.NPERIPH(NPERIPH)) u_map (
    .applied   (applied),
    .cg_off    (cg_off_q),
    .core_en   (core_clk_en),
    .bus_en    (bus_clk_en),
    .irq_en    (irq_clk_en),
    .periph_en (periph_clk_en)
  );

  always_comb begin
    unique case (bus_addr)
      A_KEY:   bus_rdata = {{(DATA_W-2){1'b0}}, stage};
      A_MODE:  bus_rdata = {{(DATA_W-2){1'b0}}, mode_q};
      A_CGOFF: bus_rdata = {{CG_PAD{1'b0}}, cg_off_q};
      default: bus_rdata = {{(DATA_W-2){1'b0}}, applied};
    endcase
  end

  // R3: the stored mode only moves after the guard was open
  a_r3_mode_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(unlocked));

  // R8: the core clock is only gated once the processor sleeps
  a_r8_core_gate_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> $past(cpu_sleep));

  // R8: interrupt clock off implies bus clock off
  a_r8_irq_implies_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_clk_en |-> !bus_clk_en);

  // R9: peripheral clocks follow the bus clock in deep modes
  a_r9_periph_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clk_en |-> (periph_clk_en == '0));
endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int NP = 8;
  localparam int NW = 8;
  localparam logic [NW-1:0] HMASK = 8'h0F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [15:0]   bus_wdata = 16'd0;
  logic [15:0]   bus_rdata;
  logic          cpu_sleep = 1'b0;
  logic [NW-1:0] wake_src = '0;
  logic          core_clk_en, bus_clk_en, irq_clk_en;
  logic [NP-1:0] periph_clk_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  int          m_lock;
  logic [1:0]  m_mode, m_app;
  logic [NP-1:0] m_off;
  logic        m_slq;

  always #10 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_sleep(cpu_sleep),
    .wake_src(wake_src), .core_clk_en(core_clk_en), .bus_clk_en(bus_clk_en),
    .irq_clk_en(irq_clk_en), .periph_clk_en(periph_clk_en)
  );

  function automatic logic f_core(logic [1:0] a); return a == 2'b00; endfunction
  function automatic logic f_bus(logic [1:0] a);  return a[1] == 1'b0; endfunction
  function automatic logic f_irq(logic [1:0] a);  return a != 2'b11; endfunction
  function automatic logic [NP-1:0] f_per(logic [1:0] a, logic [NP-1:0] off);
    return a[1] ? '0 : ~off;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_gates();
    chk("R8 core", 16'(core_clk_en), 16'(f_core(m_app)));
    chk("R8 bus", 16'(bus_clk_en), 16'(f_bus(m_app)));
    chk("R8 irq", 16'(irq_clk_en), 16'(f_irq(m_app)));
    chk("R9 periph", 16'(periph_clk_en), 16'(f_per(m_app, m_off)));
  endtask

  function automatic logic [15:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return 16'(m_lock);
      2'd1: return 16'(m_mode);
      2'd2: return 16'(m_off);
      default: return 16'(m_app);
    endcase
  endfunction

  // one clock of stimulus; model advanced at the edge, outputs checked after it
  task automatic step(logic wr, logic [1:0] a, logic [15:0] d, logic slp,
                      logic [NW-1:0] wk, string rtag);
    int       nl;
    logic [1:0] na;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; cpu_sleep = slp; wake_src = wk;
    #2;
    if (!wr) chk(rtag, bus_rdata, exp_read(a));
    nl = m_lock;
    if (wr) begin
      if (a == 2'd0) begin
        if (m_lock == 0)      nl = (d == 16'h4859) ? 1 : 0;
        else if (m_lock == 1) nl = (d == 16'hF27B) ? 2 : 0;
        else                  nl = 0;
      end else nl = 0;
    end
    na = m_app;
    if (m_app == 2'b00) begin
      if (slp && !m_slq) na = m_mode;
    end else if ((m_app == 2'b11) ? |(wk & HMASK) : |wk) na = 2'b00;
    @(posedge clk);
    if (wr && a == 2'd1 && m_lock == 2) m_mode = d[1:0];
    if (wr && a == 2'd2) m_off = d[NP-1:0];
    m_lock = nl; m_app = na; m_slq = slp;
    #2;
    chk_gates();
  endtask

  task automatic rd(logic [1:0] a, string rtag);
    step(1'b0, a, 16'd0, cpu_sleep, '0, rtag);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    step(1'b1, a, d, cpu_sleep, '0, "R6");
  endtask

  task automatic unlock_and_set(logic [1:0] md);
    wr_reg(2'd0, 16'h4859);
    wr_reg(2'd0, 16'hF27B);
    wr_reg(2'd1, {14'd0, md});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_lock = 0; m_mode = 2'b00; m_app = 2'b00; m_off = '0; m_slq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_gates();
    rd(2'd0, "R1 lock");
    rd(2'd1, "R1 mode");
    rd(2'd2, "R1 cgoff");
    rd(2'd3, "R1 applied");

    // R3 locked mode write ignored
    wr_reg(2'd1, 16'h0003);
    rd(2'd1, "R3 locked write");
    // R2 stepwise unlock
    wr_reg(2'd0, 16'h4859);
    rd(2'd0, "R2 first key");
    // R3 mode write at stage 1 ignored and relocks
    wr_reg(2'd1, 16'h0002);
    rd(2'd1, "R3 stage1 write");
    rd(2'd0, "R6 relock");
    // R5 wrong second key
    wr_reg(2'd0, 16'h4859);
    wr_reg(2'd0, 16'hF27A);
    rd(2'd0, "R5 wrong second");
    // R5 wrong first key
    wr_reg(2'd0, 16'hF27B);
    rd(2'd0, "R5 wrong first");
    // R2 full unlock, R6 clock-off write relocks
    wr_reg(2'd0, 16'h4859);
    wr_reg(2'd0, 16'hF27B);
    rd(2'd0, "R2 open");
    wr_reg(2'd2, 16'h00A5);
    rd(2'd0, "R6 cgoff relock");
    rd(2'd2, "R9 cgoff value");
    // R4 accepted write
    unlock_and_set(2'b01);
    rd(2'd1, "R4 mode stored");
    rd(2'd0, "R4 relocked");
    // R7 core sleep entry, R9 off bits honoured
    step(1'b0, 2'd3, 16'd0, 1'b1, '0, "R7");
    rd(2'd3, "R7 applied core");
    // R10 wake from core sleep by a high bit
    step(1'b0, 2'd3, 16'd0, 1'b1, 8'h80, "R10");
    rd(2'd3, "R10 woke");
    // R11 sleep held high does not re-enter
    step(1'b0, 2'd3, 16'd0, 1'b1, '0, "R11");
    rd(2'd3, "R11 no reentry");
    step(1'b0, 2'd3, 16'd0, 1'b0, '0, "R11");
    // hibernate: masked wake ignored, mask bit wakes
    unlock_and_set(2'b11);
    step(1'b0, 2'd3, 16'd0, 1'b1, '0, "R7");
    step(1'b0, 2'd3, 16'd0, 1'b1, 8'hF0, "R10");
    rd(2'd3, "R10 masked wake ignored");
    step(1'b0, 2'd3, 16'd0, 1'b1, 8'h04, "R10");
    rd(2'd1, "R10 mode kept");
    step(1'b0, 2'd3, 16'd0, 1'b0, '0, "R11");
    // R7 stored active: sleep edge changes nothing
    unlock_and_set(2'b00);
    step(1'b0, 2'd3, 16'd0, 1'b1, '0, "R7 active stays");
    step(1'b0, 2'd3, 16'd0, 1'b0, '0, "R7");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int            r;
      logic          wr, slp;
      logic [1:0]    a;
      logic [15:0]   d;
      logic [NW-1:0] wk;
      r  = $urandom_range(0, 9);
      wr = (r < 6);
      a  = 2'($urandom_range(0, 3));
      if (wr && $urandom_range(0, 2) != 0) a = ($urandom_range(0, 1) != 0) ? 2'd0 : 2'd1;
      case ($urandom_range(0, 3))
        0: d = 16'h4859;
        1: d = 16'hF27B;
        default: d = 16'($urandom);
      endcase
      slp = (m_app != 2'b00) ? 1'b1 : ($urandom_range(0, 3) == 0);
      wk  = ($urandom_range(0, 4) == 0) ? NW'($urandom) : '0;
      step(wr, a, d, slp, wk, "R2 R4 R7 R10 random");
    end
    step(1'b0, 2'd0, 16'd0, 1'b1, 8'h01, "R10");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule